// File: doc/BRIEF.md
# Fractional-increment PTP time counter

This block keeps a free-running 64-bit system time for precision time stamping. On every cycle of the timing clock the time register adds a fixed-point increment. Software obtains whole nanoseconds by shifting the register right, and the shift amount depends on the link speed. The increment is wide so that small frequency corrections fall below one nanosecond per cycle.

A restart strobe loads the default increment and shift for the current link speed and clears the time. It is normally raised after a link event. Software may also write the time or the increment directly. It can trim the rate by a signed parts-per-billion value, which is applied to the base increment for the current speed. A two-step read port returns the 64-bit time as two 32-bit halves that belong to the same instant. A parameter selects a narrow-field variant with a 24-bit increment field and a period value of one stored above that field.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, time_o is 0, inc_o is 0, rd_data_o is 0, and shift_o is 28 (21 in the narrow variant).
- R2: On each clock the time register adds the increment field: inc_o in the wide variant, inc_o[23:0] in the narrow one. An increment field of zero leaves time_o unchanged.
- R3: Speed codes on speed_i are 1 for 100M, 2 for 1G and 3 for 10G; code 0 means no link and is treated as 10G. A restart_i pulse reloads only when the treated speed differs from the stored speed or the increment field is zero. A reload loads the default increment for that speed, stores the speed, and sets the time to 0 on the next clock. Otherwise restart_i changes nothing.
- R4: The wide defaults are: 10G, increment 0x66666666 with shift 28; 1G, 0x40000000 with shift 24; 100M, 0x50000000 with shift 21. ns_o always equals time_o shifted right by shift_o.
- R5: A pulse on inc_wr_i stores inc_wdata_i into the increment register on the next clock.
- R6: A trim_i pulse sets the increment to base ± base·|ppb|/10^9, using integer division. Base is the default increment of the stored speed. The delta is added when ppb_i is positive and subtracted when it is negative. |ppb| is limited to 250,000,000.
- R7: A pulse on time_wr_i loads time_wdata_i on the next clock, and that cycle's increment is not added.
- R8: The time register wraps modulo 2^64 and does not saturate.
- R9: A rd_lo_i pulse presents time bits [31:0] on rd_data_o in the next cycle and captures bits [63:32]. A later rd_hi_i pulse presents the captured high half, however far time has moved since.
- R10: A restart that reloads takes priority over a time write and an increment write. An increment write takes priority over a trim. If rd_lo_i and rd_hi_i arrive together, rd_lo_i wins.
- R11: In the narrow variant, defaults and trim bases are the wide values shifted right by 7, and the shift is reduced by 7. Every reload or trim also sets bit 24 of the increment register (a period of one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | timing clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| speed_i | input | 2 | link speed code |
| restart_i | input | 1 | restart strobe, checked after a link event |
| time_wr_i | input | 1 | time write strobe |
| time_wdata_i | input | 64 | time write value |
| inc_wr_i | input | 1 | increment write strobe |
| inc_wdata_i | input | 32 | increment write value |
| trim_i | input | 1 | frequency trim strobe |
| ppb_i | input | 32 | signed trim in parts per billion |
| rd_lo_i | input | 1 | read low half and capture high half |
| rd_hi_i | input | 1 | read captured high half |
| rd_data_o | output | 32 | read data, valid the cycle after a read strobe |
| time_o | output | 64 | raw time register |
| ns_o | output | 64 | time in nanoseconds |
| inc_o | output | 32 | increment register |
| shift_o | output | 6 | nanosecond shift for the stored speed |

## Verification
The bench builds two copies of the block from the same stimulus: one with the default wide 32-bit increment and one with the narrow 24-bit field. The narrow copy brings the reduced shift and the period bit into reach. The 64-bit time width is kept, so the bench reaches the wrap and a carry into the high half by writing the time close to those boundaries. Trim values cover the small, clamped and most-negative ppb cases against both increment bases.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int INC_W = 32;
  localparam int SHW   = 6;

  typedef enum logic [1:0] {
    SPD_NONE = 2'd0,
    SPD_100M = 2'd1,
    SPD_1G   = 2'd2,
    SPD_10G  = 2'd3
  } speed_e;

  // no link or unknown runs at the 10G period
  function automatic speed_e eff_speed(input logic [1:0] s);
    case (s)
      2'd1:    return SPD_100M;
      2'd2:    return SPD_1G;
      default: return SPD_10G;
    endcase
  endfunction

  function automatic logic [INC_W-1:0] dflt_inc(input speed_e s);
    case (s)
      SPD_100M: return 32'h5000_0000;
      SPD_1G:   return 32'h4000_0000;
      default:  return 32'h6666_6666;
    endcase
  endfunction

  function automatic logic [SHW-1:0] dflt_shift(input speed_e s);
    case (s)
      SPD_100M: return 6'd21;
      SPD_1G:   return 6'd24;
      default:  return 6'd28;
    endcase
  endfunction
endpackage

// File: rtl/ptp_tc_inc_ctrl.sv
module ptp_tc_inc_ctrl
  import ptp_tc_pkg::*;
#(
  parameter bit NARROW  = 1'b0,
  parameter int FIELD_W = 24,
  parameter int PPB_MAX = 250_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       speed_i,
  input  logic             restart_i,
  input  logic             inc_wr_i,
  input  logic [INC_W-1:0] inc_wdata_i,
  input  logic             trim_i,
  input  logic [31:0]      ppb_i,
  output logic [INC_W-1:0] inc_o,
  output logic [INC_W-1:0] field_o,
  output logic [SHW-1:0]   shift_o,
  output logic             clr_o
);
  localparam int SH_ADJ = NARROW ? 7 : 0;
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;

  speed_e           cur_q;
  logic [INC_W-1:0] inc_q;
  logic [INC_W-1:0] new_base, cur_base;
  logic [INC_W-1:0] ld_val, trim_val;
  logic [INC_W-1:0] mag_raw, mag;
  logic [63:0]      prod, delta;
  speed_e           eff;
  logic             reload;

  assign eff      = eff_speed(speed_i);
  assign new_base = dflt_inc(eff) >> SH_ADJ;
  assign cur_base = dflt_inc(cur_q) >> SH_ADJ;
  assign shift_o  = dflt_shift(cur_q) - SHW'(SH_ADJ);

  // ppb magnitude, clamped
  assign mag_raw = ppb_i[31] ? (~ppb_i + 32'd1) : ppb_i;
  assign mag     = (mag_raw > INC_W'(PPB_MAX)) ? INC_W'(PPB_MAX) : mag_raw;
  assign prod    = {32'b0, cur_base} * {32'b0, mag};
  assign delta   = prod / NS_PER_S;

  logic [INC_W-1:0] trim_raw;
  assign trim_raw = ppb_i[31] ? (cur_base - delta[INC_W-1:0])
                              : (cur_base + delta[INC_W-1:0]);

  generate
    if (NARROW) begin : g_narrow
      localparam logic [INC_W-1:0] FMASK = (INC_W'(1) << FIELD_W) - INC_W'(1);
      localparam logic [INC_W-1:0] PERIOD = INC_W'(1) << FIELD_W;
      assign field_o  = inc_q & FMASK;
      assign ld_val   = PERIOD | (new_base & FMASK);
      assign trim_val = PERIOD | (trim_raw & FMASK);
    end else begin : g_wide
      assign field_o  = inc_q;
      assign ld_val   = new_base;
      assign trim_val = trim_raw;
    end
  endgenerate

  assign reload = restart_i && ((eff != cur_q) || (field_o == '0));
  assign clr_o  = reload;
  assign inc_o  = inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= SPD_10G;
      inc_q <= '0;
    end else if (reload) begin
      cur_q <= eff;
      inc_q <= ld_val;
    end else if (inc_wr_i) begin
      inc_q <= inc_wdata_i;
    end else if (trim_i) begin
      inc_q <= trim_val;
    end
  end

  // R3
  reload_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (field_o != '0));

  // R6
  trim_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_i && !reload && !inc_wr_i) |=>
      ({2'b0, field_o} <= {2'b0, $past(cur_base)} + {4'b0, $past(cur_base[INC_W-1:2])}) &&
      ({2'b0, field_o} + {4'b0, $past(cur_base[INC_W-1:2])} + 34'd1 >= {2'b0, $past(cur_base)}));

  // R5
  inc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_wr_i && !reload) |=> (inc_o == $past(inc_wdata_i)));
endmodule

// File: rtl/ptp_tc_time_acc.sv
module ptp_tc_time_acc
  import ptp_tc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [TIME_W-1:0] wdata_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    time_q <= '0;
    else if (clr_i) time_q <= '0;
    else if (wr_i)  time_q <= wdata_i;
    else            time_q <= time_q + TIME_W'(inc_i);  // wraps
  end

  assign time_o = time_q;

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (time_o == '0));

  // R7
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (time_o == $past(wdata_i)));

  // R2
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i && (inc_i == '0)) |=> $stable(time_o));
endmodule

// File: rtl/ptp_tc_read_latch.sv
module ptp_tc_read_latch #(
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [HALF_W-1:0] data_o
);
  logic [HALF_W-1:0] hi_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      data_q <= '0;
    end else if (rd_lo_i) begin
      data_q <= time_i[HALF_W-1:0];
      hi_q   <= time_i[TIME_W-1:HALF_W];
    end else if (rd_hi_i) begin
      data_q <= hi_q;
    end
  end

  assign data_o = data_q;

  // R9
  lo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> (data_o == $past(time_i[HALF_W-1:0])));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !rd_hi_i) |=> $stable(data_o));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter bit NARROW  = 1'b0,
  parameter int FIELD_W = 24,
  parameter int PPB_MAX = 250_000_000,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        speed_i,
  input  logic              restart_i,
  input  logic              time_wr_i,
  input  logic [TIME_W-1:0] time_wdata_i,
  input  logic              inc_wr_i,
  input  logic [INC_W-1:0]  inc_wdata_i,
  input  logic              trim_i,
  input  logic [31:0]       ppb_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] ns_o,
  output logic [INC_W-1:0]  inc_o,
  output logic [SHW-1:0]    shift_o
);
  logic [INC_W-1:0]  field;
  logic              clr;
  logic [TIME_W-1:0] time_w;

  ptp_tc_inc_ctrl #(
    .NARROW (NARROW),
    .FIELD_W(FIELD_W),
    .PPB_MAX(PPB_MAX)
  ) u_inc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_i    (speed_i),
    .restart_i  (restart_i),
    .inc_wr_i   (inc_wr_i),
    .inc_wdata_i(inc_wdata_i),
    .trim_i     (trim_i),
    .ppb_i      (ppb_i),
    .inc_o      (inc_o),
    .field_o    (field),
    .shift_o    (shift_o),
    .clr_o      (clr)
  );

  ptp_tc_time_acc #(.TIME_W(TIME_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .wr_i   (time_wr_i),
    .wdata_i(time_wdata_i),
    .inc_i  (field),
    .time_o (time_w)
  );

  ptp_tc_read_latch #(.TIME_W(TIME_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_lo_i(rd_lo_i),
    .rd_hi_i(rd_hi_i),
    .time_i (time_w),
    .data_o (rd_data_o)
  );

  assign time_o = time_w;
  assign ns_o   = time_w >> shift_o;

  // R4
  shift_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o <= 6'd28) && (shift_o >= 6'd14));
endmodule

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        restart = 1'b0, twr = 1'b0, iwr = 1'b0, trim = 1'b0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic [63:0] twdata = '0;
  logic [31:0] iwdata = '0, ppb = '0;

  logic [31:0] o_rd [2];
  logic [63:0] o_time [2];
  logic [63:0] o_ns [2];
  logic [31:0] o_inc [2];
  logic [5:0]  o_sh [2];

  int    total = 0, bad = 0;
  bit    run = 1'b0, done = 1'b0;
  string req_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  ptp_time_counter #(.NARROW(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .speed_i(speed), .restart_i(restart),
    .time_wr_i(twr), .time_wdata_i(twdata), .inc_wr_i(iwr), .inc_wdata_i(iwdata),
    .trim_i(trim), .ppb_i(ppb), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .rd_data_o(o_rd[0]), .time_o(o_time[0]), .ns_o(o_ns[0]), .inc_o(o_inc[0]),
    .shift_o(o_sh[0]));

  ptp_time_counter #(.NARROW(1'b1)) uut_nr (
    .clk_i(clk), .rst_ni(rst_n), .speed_i(speed), .restart_i(restart),
    .time_wr_i(twr), .time_wdata_i(twdata), .inc_wr_i(iwr), .inc_wdata_i(iwdata),
    .trim_i(trim), .ppb_i(ppb), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .rd_data_o(o_rd[1]), .time_o(o_time[1]), .ns_o(o_ns[1]), .inc_o(o_inc[1]),
    .shift_o(o_sh[1]));

  // reference model, index 0 wide, 1 narrow
  longint unsigned m_time [2] = '{0, 0};
  logic [31:0]     m_inc [2]  = '{0, 0};
  int              m_cur [2]  = '{3, 3};
  logic [31:0]     m_rd [2]   = '{0, 0};
  logic [31:0]     m_hi [2]   = '{0, 0};

  function automatic longint unsigned def_inc(int s, int nr);
    longint unsigned v;
    v = (s == 1) ? 64'h5000_0000 : (s == 2) ? 64'h4000_0000 : 64'h6666_6666;
    return nr ? (v >> 7) : v;
  endfunction

  function automatic int def_sh(int s, int nr);
    int v;
    v = (s == 1) ? 21 : (s == 2) ? 24 : 28;
    return nr ? v - 7 : v;
  endfunction

  function automatic logic [31:0] fld(logic [31:0] v, int nr);
    return nr ? (v & 32'h00FF_FFFF) : v;
  endfunction

  function automatic logic [31:0] pk(longint unsigned v, int nr);
    return nr ? (32'h0100_0000 | (32'(v) & 32'h00FF_FFFF)) : 32'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_time[i] = 0; m_inc[i] = 0; m_cur[i] = 3; m_rd[i] = 0; m_hi[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int eff;
        bit rl;
        longint unsigned nt, base, mag, dl;
        longint p;
        logic [31:0] ni;
        eff = (speed == 2'd1) ? 1 : (speed == 2'd2) ? 2 : 3;
        rl  = restart && ((eff != m_cur[i]) || (fld(m_inc[i], i) == 0));
        nt  = rl ? 64'd0 : twr ? twdata : m_time[i] + 64'(fld(m_inc[i], i));
        base = def_inc(m_cur[i], i);
        p    = longint'($signed(ppb));
        mag  = (p < 0) ? longint'(-p) : longint'(p);
        if (mag > 250_000_000) mag = 250_000_000;
        dl   = base * mag / 1_000_000_000;
        if (rl)        ni = pk(def_inc(eff, i), i);
        else if (iwr)  ni = iwdata;
        else if (trim) ni = pk((p < 0) ? base - dl : base + dl, i);
        else           ni = m_inc[i];
        if (rd_lo) begin
          m_rd[i] = m_time[i][31:0]; m_hi[i] = m_time[i][63:32];
        end else if (rd_hi) begin
          m_rd[i] = m_hi[i];
        end
        m_time[i] = nt;
        m_inc[i]  = ni;
        if (rl) m_cur[i] = eff;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run) begin
      for (int i = 0; i < 2; i++) begin
        string t;
        t = (i == 1) ? "R11" : req_tag;
        chk(o_time[i] == m_time[i], t, "time", o_time[i], m_time[i]);
        chk(o_inc[i] == m_inc[i], t, "inc", 64'(o_inc[i]), 64'(m_inc[i]));
        chk(int'(o_sh[i]) == def_sh(m_cur[i], i), "R4", "shift",
            64'(o_sh[i]), 64'(def_sh(m_cur[i], i)));
        chk(o_ns[i] == (m_time[i] >> def_sh(m_cur[i], i)), "R4", "ns",
            o_ns[i], m_time[i] >> def_sh(m_cur[i], i));
        chk(o_rd[i] == m_rd[i], t, "rd_data", 64'(o_rd[i]), 64'(m_rd[i]));
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart(logic [1:0] s);
    speed = s; restart = 1'b1; cyc(1); restart = 1'b0;
  endtask

  task automatic do_trim(logic [31:0] p);
    ppb = p; trim = 1'b1; cyc(1); trim = 1'b0;
  endtask

  initial begin
    logic [63:0] snap;
    logic [63:0] t0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(o_time[0] == 0 && o_inc[0] == 0 && o_rd[0] == 0, "R1", "reset wide",
        o_time[0], 64'd0);
    chk(o_sh[0] == 6'd28 && o_sh[1] == 6'd21, "R1", "reset shift",
        {o_sh[0], o_sh[1]}, {6'd28, 6'd21});
    run = 1'b1;
    req_tag = "R2";
    cyc(5);
    chk(o_time[0] == 0, "R2", "frozen at zero inc", o_time[0], 64'd0);

    req_tag = "R3";
    do_restart(2'd3);
    chk(o_inc[0] == 32'h6666_6666, "R3", "reload 10G", 64'(o_inc[0]), 64'h6666_6666);
    cyc(10);
    t0 = o_time[0];
    do_restart(2'd3);
    chk(o_time[0] == t0 + 64'h6666_6666, "R3", "restart ignored", o_time[0],
        t0 + 64'h6666_6666);
    cyc(5);
    req_tag = "R4";
    do_restart(2'd2); cyc(8);
    chk(o_sh[0] == 6'd24, "R4", "1G shift", 64'(o_sh[0]), 64'd24);
    do_restart(2'd1); cyc(8);
    chk(o_inc[0] == 32'h5000_0000, "R4", "100M inc", 64'(o_inc[0]), 64'h5000_0000);
    do_restart(2'd0); cyc(8);
    chk(o_sh[0] == 6'd28, "R4", "no link as 10G", 64'(o_sh[0]), 64'd28);

    req_tag = "R5";
    iwdata = 32'h0000_1234; iwr = 1'b1; cyc(1); iwr = 1'b0;
    chk(o_inc[0] == 32'h1234, "R5", "inc write", 64'(o_inc[0]), 64'h1234);
    cyc(6);
    req_tag = "R2";
    iwdata = 32'h0; iwr = 1'b1; cyc(1); iwr = 1'b0;
    t0 = o_time[0];
    cyc(4);
    chk(o_time[0] == t0, "R2", "frozen after zero write", o_time[0], t0);
    req_tag = "R3";
    do_restart(2'd0); cyc(4);

    req_tag = "R6";
    do_trim(32'd1000);             cyc(3);
    do_trim(-32'sd1000);           cyc(3);
    do_trim(32'd300_000_000);      cyc(3);
    chk(o_inc[0] == 32'h6666_6666 + 32'h1999_9999, "R6", "clamped positive",
        64'(o_inc[0]), 64'(32'h6666_6666 + 32'h1999_9999));
    do_trim(32'h8000_0000);        cyc(3);
    do_trim(32'd12_345_678);       cyc(3);
    do_restart(2'd1);
    do_trim(-32'sd77_777);         cyc(3);
    do_restart(2'd3);              cyc(2);

    req_tag = "R7";
    twdata = 64'h0000_0001_0000_0000; twr = 1'b1; cyc(1); twr = 1'b0;
    chk(o_time[0] == 64'h0000_0001_0000_0000, "R7", "time write", o_time[0],
        64'h0000_0001_0000_0000);
    cyc(3);

    req_tag = "R8";
    twdata = 64'hFFFF_FFFF_FFFF_FF00; twr = 1'b1; cyc(1); twr = 1'b0;
    cyc(1);
    chk(o_time[0] == 64'hFFFF_FFFF_FFFF_FF00 + 64'h6666_6666, "R8", "wrap",
        o_time[0], 64'hFFFF_FFFF_FFFF_FF00 + 64'h6666_6666);
    cyc(3);

    req_tag = "R9";
    twdata = 64'h0000_0005_FFFF_FF00; twr = 1'b1; cyc(1); twr = 1'b0;
    snap = o_time[0];
    rd_lo = 1'b1; cyc(1); rd_lo = 1'b0;
    chk(o_rd[0] == snap[31:0], "R9", "low half", 64'(o_rd[0]), 64'(snap[31:0]));
    cyc(3);
    rd_hi = 1'b1; cyc(1); rd_hi = 1'b0;
    chk(o_rd[0] == snap[63:32], "R9", "coherent high", 64'(o_rd[0]), 64'(snap[63:32]));
    chk(o_time[0][63:32] != snap[63:32], "R9", "high moved on", o_time[0], snap);
    cyc(2);

    req_tag = "R10";
    speed = 2'd2; restart = 1'b1; twr = 1'b1; twdata = 64'h1234_5678;
    iwr = 1'b1; iwdata = 32'h55;
    cyc(1); restart = 1'b0; twr = 1'b0; iwr = 1'b0;
    chk(o_time[0] == 0 && o_inc[0] == 32'h4000_0000, "R10", "reload wins",
        o_time[0], 64'd0);
    iwr = 1'b1; iwdata = 32'h777; trim = 1'b1; ppb = 32'd5000;
    cyc(1); iwr = 1'b0; trim = 1'b0;
    chk(o_inc[0] == 32'h777, "R10", "write beats trim", 64'(o_inc[0]), 64'h777);
    rd_lo = 1'b1; rd_hi = 1'b1; cyc(1); rd_lo = 1'b0; rd_hi = 1'b0;
    cyc(3);

    run = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule